// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block sits between a synchronous host request channel and an asynchronous fast-page-mode DRAM array. The array has two rank strobes and a 40-bit data path. A host request carries a rank, a row and a column, and moves on a valid/ready handshake. The controller turns it into a strobe sequence. The row is placed on a shared 10-bit address bus and latched by the row strobe of the selected rank. The column follows on the same bus and is latched by the column strobe. Read data is captured and returned as a one-cycle response pulse.

After an access the row stays open. A later request to the same rank and row costs only a column-strobe cycle. A request to another row closes the page with a full row precharge before the new row is opened. The page is also closed before the row strobe has been low for its maximum allowed time. Writes use early-write cycles: the write strobe falls before the column strobe, so the DRAM outputs stay high-impedance and the output enable stays inactive.

An external refresh scheduler raises a request line. At the next access boundary the controller closes any open page, waits out the precharge, and grants the pins. While the grant is held, every strobe stays inactive and the data bus is released.

All DRAM timings are given as clock-cycle parameters. The defaults suit the slower speed grade at a 250 MHz clock.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: During and right after reset, all row strobes, the column strobe, the write strobe and the output enable are high. The data-bus enable, the response pulse and the refresh grant are low. After reset release, `req_ready` is high while no refresh is requested.
- R2: Only one row strobe is low at a time: `dram_ras_n[r]` for the request's rank r. At the row-strobe falling edge the bus carries the request row, and at the column-strobe falling edge it carries the request column. A read of a location returns the data most recently written to that rank, row and column.
- R3: The column strobe falls only while a row strobe is low, and at least RCD_CYC cycles after that strobe fell. The row address stays on the bus for at least RAH_CYC cycles after the row strobe falls.
- R4: The column strobe stays low for at least CAS_CYC cycles. Read data is sampled when it rises, which is no earlier than RAC_CYC cycles after the row strobe fell. Each read produces exactly one `rsp_valid` pulse, in request order.
- R5: A request to the open rank and row causes no row-strobe transition, only a column-strobe cycle.
- R6: A request to a different row, or a different rank, closes the page. All row strobes then stay high for at least RP_CYC cycles before the next row strobe falls.
- R7: Between two column-strobe pulses in one open page, the column strobe stays high for at least max(CP_CYC, PC_CYC-CAS_CYC) cycles. A full column cycle lasts at least PC_CYC cycles.
- R8: In a write, the write strobe falls and write data is driven (`dram_dq_oe`=1) at least one cycle before the column strobe falls. The output enable stays high while the write strobe is low.
- R9: After a read's column strobe rises, the controller does not raise `dram_dq_oe` for at least OFF_CYC cycles.
- R10: No row strobe stays low longer than RAS_MAX_CYC cycles. An idle open page, or a long run of page hits, is closed on its own.
- R11: `ref_gnt` rises only with all row strobes high and precharge complete. It stays high while `ref_req` is high. While it is high, every strobe is inactive, the data bus is released and `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Request accepted this cycle when high with valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_rank | input | RANK_W | Rank select (row strobe index) |
| req_row | input | ADDR_W | Row address |
| req_col | input | ADDR_W | Column address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | DATA_W | Read data |
| ref_req | input | 1 | Refresh scheduler wants the DRAM |
| ref_gnt | output | 1 | DRAM handed to the refresh scheduler |
| dram_addr | output | ADDR_W | Multiplexed row/column address |
| dram_ras_n | output | NUM_RANKS | Row strobes, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | DATA_W | Write data to the DRAM |
| dram_dq_oe | output | 1 | Controller drives the data bus |
| dram_dq_in | input | DATA_W | Read data from the DRAM |

## Verification
The assertions assume three things about the inputs. `req_valid` and the request fields stay stable until acceptance. `ref_req` stays high until it is granted. The DRAM data input is settled at the sampling edge. The stimulus drives every input half a cycle away from the active edge and holds each request until `req_ready` is seen. A bench DRAM model returns junk unless the column strobe has been low for CAS_CYC cycles and the row strobe for RAC_CYC cycles, so early sampling shows up as bad data. The random phase draws rows from a small pool, so both page hits and page misses occur. It mixes in refresh requests, and idle gaps longer than the row-strobe limit.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,   // no page open, precharge done
    ST_ROW,    // row address on bus, row strobe about to fall
    ST_RCD,    // row strobe low, waiting for column strobe
    ST_CAS,    // column strobe low
    ST_OPEN,   // page open, column strobe high
    ST_PRE,    // row precharge
    ST_REF     // pins handed to refresh scheduler
  } fpm_state_e;

  function automatic int fpm_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/fpm_page_tracker.sv
module fpm_page_tracker #(
  parameter int NUM_RANKS   = 2,
  parameter int ADDR_W      = 10,
  parameter int RAS_MAX_CYC = 25000,
  parameter int GUARD_CYC   = 24900,
  localparam int RANK_W = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
  localparam int AGE_W  = $clog2(RAS_MAX_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              open_i,
  input  logic              close_i,
  input  logic [RANK_W-1:0] rank_i,
  input  logic [ADDR_W-1:0] row_i,
  input  logic [RANK_W-1:0] cmp_rank_i,
  input  logic [ADDR_W-1:0] cmp_row_i,
  output logic              hit_o,
  output logic              aged_o,
  output logic [AGE_W-1:0]  age_o
);
  logic              open_q;
  logic [RANK_W-1:0] rank_q;
  logic [ADDR_W-1:0] row_q;
  logic [AGE_W-1:0]  age_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      rank_q <= '0;
      row_q  <= '0;
      age_q  <= '0;
    end else if (open_i) begin
      open_q <= 1'b1;
      rank_q <= rank_i;
      row_q  <= row_i;
      age_q  <= '0;
    end else if (close_i) begin
      open_q <= 1'b0;
      age_q  <= '0;
    end else if (open_q && age_q != AGE_W'(RAS_MAX_CYC)) begin
      age_q <= age_q + 1'b1;
    end
  end

  assign hit_o  = open_q && (rank_q == cmp_rank_i) && (row_q == cmp_row_i);
  assign aged_o = open_q && (age_q >= AGE_W'(GUARD_CYC));
  assign age_o  = age_q;

  // A page is opened only after the previous one was closed
  assert_open_once_R6: assert property (@(posedge clk) disable iff (rst)
    open_i |-> !open_q);
  // The close request arrives before the age counter saturates
  assert_age_limit_R10: assert property (@(posedge clk) disable iff (rst)
    open_q |-> (age_q < AGE_W'(RAS_MAX_CYC)));
endmodule

// File: rtl/fpm_bus_turn.sv
module fpm_bus_turn #(
  parameter int OFF_CYC = 5,
  localparam int CNT_W = $clog2(OFF_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic read_end_i,
  input  logic dq_oe_i,
  output logic clear_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (read_end_i)    cnt_q <= CNT_W'(OFF_CYC);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign clear_o = (cnt_q == '0);

  // Write data is never driven while the DRAM may still be driving
  assert_turnaround_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(dq_oe_i) |-> clear_o);
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
  import fpm_pkg::*;
#(
  parameter int NUM_RANKS   = 2,
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 40,
  parameter int RAH_CYC     = 3,
  parameter int RCD_CYC     = 5,
  parameter int CAS_CYC     = 5,
  parameter int CP_CYC      = 3,
  parameter int PC_CYC      = 12,
  parameter int RAC_CYC     = 18,
  parameter int RP_CYC      = 13,
  parameter int OFF_CYC     = 5,
  parameter int RAS_MAX_CYC = 25000,
  localparam int RANK_W = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [RANK_W-1:0] req_rank,
  input  logic [ADDR_W-1:0] req_row,
  input  logic [ADDR_W-1:0] req_col,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              ref_req,
  output logic              ref_gnt,
  output logic [ADDR_W-1:0] dram_addr,
  output logic [NUM_RANKS-1:0] dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic              dram_oe_n,
  output logic [DATA_W-1:0] dram_dq_out,
  output logic              dram_dq_oe,
  input  logic [DATA_W-1:0] dram_dq_in
);
  localparam int CP_HI     = fpm_max(CP_CYC, PC_CYC - CAS_CYC);
  localparam int GUARD_CYC = RAS_MAX_CYC - (CP_HI + RCD_CYC + CAS_CYC + RAC_CYC + 4);
  localparam int TMR_W     = $clog2(RP_CYC + RCD_CYC + CAS_CYC + CP_HI + 2) + 1;
  localparam int AGE_W     = $clog2(RAS_MAX_CYC + 1);
  localparam logic [TMR_W-1:0] T_RAH = TMR_W'(RAH_CYC - 1);
  localparam logic [TMR_W-1:0] T_RCD = TMR_W'(RCD_CYC - 1);
  localparam logic [TMR_W-1:0] T_CAS = TMR_W'(CAS_CYC - 1);
  localparam logic [TMR_W-1:0] T_CP  = TMR_W'(CP_HI - 1);
  localparam logic [TMR_W-1:0] T_RP  = TMR_W'(RP_CYC - 1);
  localparam logic [AGE_W-1:0] T_RAC = AGE_W'(RAC_CYC - 1);

  fpm_state_e state_q;
  logic [TMR_W-1:0] tmr_q;
  logic [RANK_W-1:0] cur_rank_q;
  logic [ADDR_W-1:0] cur_row_q, cur_col_q;
  logic [DATA_W-1:0] cur_wd_q;
  logic              cur_wr_q;

  logic [NUM_RANKS-1:0] ras_n_q;
  logic cas_n_q, we_n_q, oe_n_q, dq_oe_q, rsp_valid_q, gnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] dq_out_q, rdata_q;

  logic hit, aged, bus_clear, cp_done, must_close, open_pg, close_pg, read_end, cas_done;
  logic [AGE_W-1:0] ras_age;

  assign cp_done    = (state_q == ST_OPEN) && (tmr_q >= T_CP);
  assign must_close = ref_req || aged || (req_valid && !hit);
  assign open_pg    = (state_q == ST_ROW);
  assign close_pg   = cp_done && must_close;
  assign cas_done   = (state_q == ST_CAS) && (tmr_q >= T_CAS) && (ras_age >= T_RAC);
  assign read_end   = cas_done && !cur_wr_q;

  assign req_ready = !ref_req &&
                     ((state_q == ST_IDLE) ||
                      (cp_done && !aged && req_valid && hit && (!req_write || bus_clear)));

  fpm_page_tracker #(
    .NUM_RANKS(NUM_RANKS), .ADDR_W(ADDR_W),
    .RAS_MAX_CYC(RAS_MAX_CYC), .GUARD_CYC(GUARD_CYC)
  ) u_page (
    .clk(clk), .rst(rst), .open_i(open_pg), .close_i(close_pg),
    .rank_i(cur_rank_q), .row_i(cur_row_q),
    .cmp_rank_i(req_rank), .cmp_row_i(req_row),
    .hit_o(hit), .aged_o(aged), .age_o(ras_age)
  );

  fpm_bus_turn #(.OFF_CYC(OFF_CYC)) u_turn (
    .clk(clk), .rst(rst), .read_end_i(read_end),
    .dq_oe_i(dq_oe_q), .clear_o(bus_clear)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      tmr_q      <= '0;
      cur_rank_q <= '0;
      cur_row_q  <= '0;
      cur_col_q  <= '0;
      cur_wd_q   <= '0;
      cur_wr_q   <= 1'b0;
      ras_n_q    <= '1;
      cas_n_q    <= 1'b1;
      we_n_q     <= 1'b1;
      oe_n_q     <= 1'b1;
      dq_oe_q    <= 1'b0;
      dq_out_q   <= '0;
      addr_q     <= '0;
      rsp_valid_q <= 1'b0;
      rdata_q    <= '0;
      gnt_q      <= 1'b0;
    end else begin
      rsp_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (ref_req) begin
            gnt_q   <= 1'b1;
            state_q <= ST_REF;
          end else if (req_valid) begin
            cur_rank_q <= req_rank;
            cur_row_q  <= req_row;
            cur_col_q  <= req_col;
            cur_wr_q   <= req_write;
            cur_wd_q   <= req_wdata;
            addr_q     <= req_row;
            state_q    <= ST_ROW;
          end
        end
        ST_ROW: begin
          ras_n_q <= ~(NUM_RANKS'(1) << cur_rank_q);
          tmr_q   <= '0;
          state_q <= ST_RCD;
        end
        ST_RCD: begin
          tmr_q <= tmr_q + 1'b1;
          if (tmr_q == T_RAH) begin
            addr_q <= cur_col_q;
            if (cur_wr_q) begin
              we_n_q   <= 1'b0;
              dq_oe_q  <= 1'b1;
              dq_out_q <= cur_wd_q;
            end
          end
          if (tmr_q == T_RCD) begin
            cas_n_q <= 1'b0;
            oe_n_q  <= cur_wr_q;
            tmr_q   <= '0;
            state_q <= ST_CAS;
          end
        end
        ST_CAS: begin
          tmr_q <= tmr_q + 1'b1;
          if (cas_done) begin
            cas_n_q <= 1'b1;
            oe_n_q  <= 1'b1;
            we_n_q  <= 1'b1;
            dq_oe_q <= 1'b0;
            if (!cur_wr_q) begin
              rsp_valid_q <= 1'b1;
              rdata_q     <= dram_dq_in;
            end
            tmr_q   <= '0;
            state_q <= ST_OPEN;
          end
        end
        ST_OPEN: begin
          if (!cp_done) begin
            tmr_q <= tmr_q + 1'b1;
          end else if (must_close) begin
            ras_n_q <= '1;
            tmr_q   <= '0;
            state_q <= ST_PRE;
          end else if (req_ready) begin
            cur_col_q <= req_col;
            cur_wr_q  <= req_write;
            cur_wd_q  <= req_wdata;
            addr_q    <= req_col;
            if (req_write) begin
              we_n_q   <= 1'b0;
              dq_oe_q  <= 1'b1;
              dq_out_q <= req_wdata;
            end
            tmr_q   <= T_RCD;
            state_q <= ST_RCD;
          end
        end
        ST_PRE: begin
          tmr_q <= tmr_q + 1'b1;
          if (tmr_q == T_RP) state_q <= ST_IDLE;
        end
        ST_REF: begin
          if (!ref_req) begin
            gnt_q   <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign dram_addr   = addr_q;
  assign dram_ras_n  = ras_n_q;
  assign dram_cas_n  = cas_n_q;
  assign dram_we_n   = we_n_q;
  assign dram_oe_n   = oe_n_q;
  assign dram_dq_out = dq_out_q;
  assign dram_dq_oe  = dq_oe_q;
  assign rsp_valid   = rsp_valid_q;
  assign rsp_rdata   = rdata_q;
  assign ref_gnt     = gnt_q;

  // Only one rank is ever activated
  assert_one_rank_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~ras_n_q));
  // Row address already settled on the bus when the row strobe falls
  assert_row_setup_R2: assert property (@(posedge clk) disable iff (rst)
    (($past(ras_n_q) == '1) && (ras_n_q != '1)) |-> $stable(addr_q));
  // Column strobe only inside an active row
  assert_cas_in_row_R3: assert property (@(posedge clk) disable iff (rst)
    !cas_n_q |-> (ras_n_q != '1));
  // Early write: write strobe and data lead the column strobe
  assert_early_write_R8: assert property (@(posedge clk) disable iff (rst)
    ($fell(cas_n_q) && !we_n_q) |-> ($past(!we_n_q) && $past(dq_oe_q)));
  assert_write_no_oe_R8: assert property (@(posedge clk) disable iff (rst)
    !we_n_q |-> (oe_n_q && dq_oe_q));
  // Granted pins are quiet
  assert_grant_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    gnt_q |-> ((ras_n_q == '1) && cas_n_q && we_n_q && !dq_oe_q && !req_ready));
  // One response per completed read, never during a write
  assert_rsp_read_only_R4: assert property (@(posedge clk) disable iff (rst)
    rsp_valid_q |-> ($past(!cas_n_q) && cas_n_q && $past(we_n_q)));
endmodule

// File: tb/test_fpm_dram_ctrl.sv
`timescale 1ns/1ps
module test_fpm_dram_ctrl;
  localparam int RAH = 3, RCD = 5, CASC = 5, CP = 3, PC = 12, RAC = 18;
  localparam int RP = 13, OFF = 5, RAS_MAX = 400;
  localparam int CP_HI = (CP > PC - CASC) ? CP : PC - CASC;
  localparam logic [39:0] JUNK = 40'h5A_A5C3_3C96;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1;
  logic req_valid = 0, req_write = 0, req_rank = 0;
  logic [9:0] req_row = 0, req_col = 0;
  logic [39:0] req_wdata = 0;
  logic req_ready, rsp_valid, ref_gnt;
  logic ref_req = 0;
  logic [39:0] rsp_rdata, dq_out, dq_in = 0;
  logic [9:0] addr;
  logic [1:0] ras_n;
  logic cas_n, we_n, oe_n, dq_oe;

  fpm_dram_ctrl #(.RAH_CYC(RAH), .RCD_CYC(RCD), .CAS_CYC(CASC), .CP_CYC(CP),
    .PC_CYC(PC), .RAC_CYC(RAC), .RP_CYC(RP), .OFF_CYC(OFF), .RAS_MAX_CYC(RAS_MAX))
  i_fpm_dram_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_rank(req_rank), .req_row(req_row), .req_col(req_col),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ref_req(ref_req), .ref_gnt(ref_gnt), .dram_addr(addr), .dram_ras_n(ras_n),
    .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_oe_n(oe_n), .dram_dq_out(dq_out),
    .dram_dq_oe(dq_oe), .dram_dq_in(dq_in));

  int n_cmp = 0, n_bad = 0, ras_falls = 0;
  logic [39:0] shadow[int];
  logic [39:0] dmem[int];
  logic [39:0] exp_q[$];

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int mkey(input int rank, input int row, input int col);
    return (rank << 20) | (row << 10) | col;
  endfunction

  function automatic logic [39:0] dflt(input int key);
    return (40'(key) * 40'd2654435761) ^ 40'h3C_0FF0_A55A;
  endfunction

  function automatic logic [39:0] shadow_rd(input int key);
    return shadow.exists(key) ? shadow[key] : dflt(key);
  endfunction

  // DRAM model and protocol monitor, sampled at the falling edge
  bit prev_low = 0, prev_cas = 1, prev_we = 1, prev_oe = 1, prev_dqoe = 0, first_cas = 1;
  int age = 0, low_run = 0, hi_run = 1000, cas_run = 0, cas_hi = 0, last_low = 0, off_run = 1000;
  int m_rank = 0, m_row = 0, m_col = 0;

  always @(negedge clk) begin
    if (rst) begin
      prev_low = 0; prev_cas = 1; prev_we = 1; prev_oe = 1; prev_dqoe = 0;
      hi_run = 1000; off_run = 1000; low_run = 0;
    end else begin
      automatic bit low = (ras_n != 2'b11);
      if (low && !prev_low) begin
        check(hi_run >= RP, "R6 row precharge cycles", hi_run, RP);
        m_rank = (ras_n == 2'b10) ? 0 : 1;
        m_row = addr; age = 0; low_run = 1; first_cas = 1; ras_falls++;
      end else if (low) begin
        age++; low_run++;
      end
      if (!low && prev_low) check(low_run <= RAS_MAX, "R10 row strobe low time", low_run, RAS_MAX);
      hi_run = low ? 0 : hi_run + 1;
      if (low && age == RAH - 1) check(addr == 10'(m_row), "R3 row address hold", addr, m_row);
      if (!cas_n && prev_cas) begin
        check(low, "R3 column strobe inside row", ras_n, 0);
        check(age >= RCD, "R3 row-to-column delay", age, RCD);
        if (!first_cas) begin
          check(cas_hi >= CP_HI, "R7 column precharge", cas_hi, CP_HI);
          check(cas_hi + last_low >= PC, "R7 page cycle", cas_hi + last_low, PC);
        end
        first_cas = 0; m_col = addr; cas_run = 1;
        if (!we_n) begin
          check(!prev_we && prev_dqoe && oe_n, "R8 early write", {prev_we, prev_dqoe, oe_n}, 3'b011);
          dmem[mkey(m_rank, m_row, m_col)] = dq_out;
        end
      end else if (!cas_n) cas_run++;
      if (cas_n && !prev_cas) begin
        last_low = cas_run; cas_hi = 1;
        check(last_low >= CASC, "R4 column strobe width", last_low, CASC);
        if (!prev_oe) off_run = 0;
      end else if (cas_n) cas_hi++;
      if (dq_oe && !prev_dqoe) check(off_run >= OFF, "R9 bus turnaround", off_run, OFF);
      off_run++;
      if (!cas_n && !oe_n && we_n && cas_run >= CASC && age >= RAC - 1) begin
        automatic int k = mkey(m_rank, m_row, m_col);
        dq_in = dmem.exists(k) ? dmem[k] : dflt(k);
      end else dq_in = JUNK;
      if (ref_gnt)
        check(ras_n == 2'b11 && cas_n && we_n && !dq_oe && !req_ready, "R11 grant quiet",
              {ras_n, cas_n, we_n, dq_oe, req_ready}, 6'b111100);
      if (rsp_valid) begin
        if (exp_q.size() == 0) check(0, "R4 unexpected response", rsp_rdata, 0);
        else begin
          automatic logic [39:0] e = exp_q.pop_front();
          check(rsp_rdata == e, "R2 R4 read data", rsp_rdata, e);
        end
      end
      prev_low = low; prev_cas = cas_n; prev_we = we_n; prev_oe = oe_n; prev_dqoe = dq_oe;
    end
  end

  task automatic issue(input int rank, input int row, input int col, input bit wr, input logic [39:0] wd);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_rank = rank[0]; req_row = 10'(row);
    req_col = 10'(col); req_wdata = wd;
    forever begin
      #1;
      if (req_ready) break;
      @(negedge clk);
    end
    if (wr) shadow[mkey(rank, row, col)] = wd;
    else exp_q.push_back(shadow_rd(mkey(rank, row, col)));
    @(posedge clk);
    #1 req_valid = 0;
  endtask

  task automatic refresh(input int hold);
    int waited = 0;
    @(negedge clk);
    ref_req = 1;
    while (!ref_gnt && waited < 200) begin @(negedge clk); waited++; end
    check(ref_gnt == 1, "R11 grant reached", waited, 0);
    repeat (hold) @(negedge clk);
    ref_req = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_cmp, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int base;
    void'($urandom(32'h1F2E3D4C));
    repeat (4) @(negedge clk);
    // R1 reset values
    check(ras_n == 2'b11 && cas_n && we_n && oe_n, "R1 strobes in reset", {ras_n, cas_n, we_n, oe_n}, 5'h1f);
    check(!dq_oe && !rsp_valid && !ref_gnt, "R1 bus and grant in reset", {dq_oe, rsp_valid, ref_gnt}, 0);
    rst = 0;
    @(negedge clk);
    check(req_ready == 1, "R1 ready after reset", req_ready, 1);

    // R5: page hits only toggle the column strobe
    base = ras_falls;
    issue(0, 5, 1, 1, 40'hAB_CDEF_0123);
    issue(0, 5, 1, 0, 0);
    issue(0, 5, 2, 1, 40'h11_2233_4455);
    issue(0, 5, 2, 0, 0);
    issue(0, 5, 900, 0, 0);
    repeat (30) @(negedge clk);
    check(ras_falls - base == 1, "R5 page hit row opens", ras_falls - base, 1);

    // R6: row miss and rank change reopen
    issue(0, 6, 1, 0, 0);
    issue(1, 6, 1, 1, 40'hFF_0000_FFFF);
    issue(1, 6, 1, 0, 0);
    repeat (30) @(negedge clk);
    check(ras_falls - base == 3, "R6 miss reopens row", ras_falls - base, 3);

    // R11: refresh closes an open page
    refresh(15);
    base = ras_falls;
    issue(1, 6, 1, 0, 0);
    repeat (30) @(negedge clk);
    check(ras_falls - base == 1, "R11 page closed by refresh", ras_falls - base, 1);

    // R10: idle page closes itself
    repeat (RAS_MAX + 50) @(negedge clk);
    check(ras_n == 2'b11, "R10 idle page closed", ras_n, 2'b11);

    // R10: a long run of hits is broken up
    base = ras_falls;
    for (int i = 0; i < 40; i++) issue(0, 9, i, 0, 0);
    repeat (40) @(negedge clk);
    check(ras_falls - base >= 2, "R10 hit run reopened", ras_falls - base, 2);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      automatic int r = $urandom_range(0, 99);
      automatic int rows[3] = '{3, 7, 1023};
      if (r < 4) refresh($urandom_range(2, 20));
      else if (r < 7) repeat (RAS_MAX + 20) @(negedge clk);
      else repeat ($urandom_range(0, 3)) @(negedge clk);
      issue($urandom_range(0, 1), rows[$urandom_range(0, 2)], $urandom_range(0, 31),
            $urandom_range(0, 1), {$urandom, 8'($urandom)});
    end

    for (int i = 0; i < 2000 && exp_q.size() != 0; i++) @(negedge clk);
    check(exp_q.size() == 0, "R4 all reads answered", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule